// File: doc/BRIEF.md
# Three-Buffer Transmit Priority Arbiter

This block decides which of three transmit buffers a CAN controller serializes next. Each buffer presents a request bit, an identifier with a flag for standard or extended format, and an 8-bit priority value. A single mode input selects the ranking key for all buffers: either the identifier or the priority value. The smallest key among the requesting buffers wins. When keys are equal, the lowest buffer number wins.

The choice is recomputed continuously from the current buffer state, so a buffer that was enabled after earlier frames competes at the next frame start. When the transmitter begins a frame it pulses a start strobe. The arbiter then captures the current winner and holds it until the frame completes or is aborted. Frame serialization, loss of bus arbitration and buffer storage belong to neighbouring logic.

Top module: `txprio_arbiter`

## Requirements
- R1: When no buffer has its request bit (bit i of `tx_req` for buffer i) set, `next_valid` is 0.
- R2: With `rank_by_prio` = 0, `next_idx` names the requesting buffer with the smallest identifier key.
- R3: With `rank_by_prio` = 1, `next_idx` names the requesting buffer with the smallest 8-bit priority value, and identifiers have no effect on the choice.
- R4: When several requesting buffers share the smallest key, the one with the lowest index wins.
- R5: A buffer whose request bit is 0 is never chosen, even if its key is the smallest; whenever `next_valid` is 1, the named buffer is requesting.
- R6: A buffer whose `tx_ext` bit is 0 carries an 11-bit identifier in bits 10:0 of its identifier field. Bits 28:11 are ignored, and the value is zero-extended before it is compared with 29-bit extended identifiers.
- R7: A `frame_start` pulse while idle and while `next_valid` is 1 sets `frame_active` on the next clock edge, and `frame_idx` takes the value `next_idx` had at that edge.
- R8: While `frame_active` is 1 and no done or abort pulse arrives, `frame_idx` holds its value. This holds when requests or keys change, and further `frame_start` pulses are ignored.
- R9: A `frame_done` or `frame_abort` pulse while active clears `frame_active` on the next edge; the next start then captures the winner recomputed from the buffer state at that time.
- R10: A `frame_start` pulse while `next_valid` is 0 leaves `frame_active` at 0.
- R11: After synchronous reset, `frame_active` is 0 and `frame_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rank_by_prio | input | 1 | 0: rank by identifier, 1: rank by priority value |
| tx_req | input | 3 | Request bit per buffer, bit i for buffer i |
| tx_ext | input | 3 | Extended-identifier flag per buffer |
| tx_id | input | 3*ID_W | Identifiers, buffer i at bits i*ID_W +: ID_W |
| tx_prio | input | 3*PRIO_W | Priority values, buffer i at bits i*PRIO_W +: PRIO_W |
| frame_start | input | 1 | Transmitter starts a new frame |
| frame_done | input | 1 | Current frame finished |
| frame_abort | input | 1 | Current frame abandoned |
| next_valid | output | 1 | At least one buffer is requesting |
| next_idx | output | 2 | Live winner index |
| frame_active | output | 1 | A frame choice is held |
| frame_idx | output | 2 | Buffer index held for the current frame |

## Verification
The bench uses the default parameters: a 29-bit identifier, an 11-bit standard field and an 8-bit priority value. These widths make the key in identifier mode wider than the key in priority mode. They also allow standard identifiers to carry nonzero upper bits, so the bench can confirm that zero-extension masks those bits. Vectors are chosen so that the identifier order and the priority order disagree, and the two modes therefore pick different buffers. A buffer with the smallest key but no request is also included, so that the rule excluding non-requesting buffers is tested.

// File: rtl/txarb_pkg.sv
// Shared constants for the transmit priority arbiter.
// Assumes a fixed contest of three buffers; index width follows from that.
package txarb_pkg;
    localparam int NUM_BUF = 3;
    localparam int IDX_W   = $clog2(NUM_BUF);
    typedef logic [IDX_W-1:0] buf_idx_t;
endpackage

// File: rtl/txarb_keyform.sv
// Forms the ranking key of one buffer.
// In priority mode the key is the zero-extended priority value. In identifier mode
// it is the full identifier, or the low STD_W bits zero-extended for a standard frame.
// Assumes KEY_W >= ID_W, KEY_W >= PRIO_W and STD_W <= ID_W.
module txarb_keyform #(
    parameter int ID_W   = 29,
    parameter int STD_W  = 11,
    parameter int PRIO_W = 8,
    parameter int KEY_W  = 29
) (
    input  logic              rank_by_prio,
    input  logic              is_ext,
    input  logic [ID_W-1:0]   id,
    input  logic [PRIO_W-1:0] prio,
    output logic [KEY_W-1:0]  key
);
    logic [KEY_W-1:0] id_key;

    // Masks standard identifiers down to their defined field.
    always_comb begin
        if (is_ext) id_key = KEY_W'(id);
        else        id_key = KEY_W'(id[STD_W-1:0]);
    end

    // Picks the key source by mode.
    always_comb begin
        if (rank_by_prio) key = KEY_W'(prio);
        else              key = id_key;
    end
endmodule

// File: rtl/txarb_minsel.sv
// Finds the requesting entry with the smallest key.
// Entries are scanned from index 0 upward with a strict less-than, so equal keys
// keep the earlier (lower) index. Assumes NUM fits in IDX_W bits.
module txarb_minsel #(
    parameter int NUM   = 3,
    parameter int KEY_W = 29,
    parameter int IDX_W = 2
) (
    input  logic [NUM-1:0]            req,
    input  logic [NUM-1:0][KEY_W-1:0] keys,
    output logic                      found,
    output logic [IDX_W-1:0]          win_idx
);
    logic [KEY_W-1:0] best_key;

    // Linear scan keeping the smallest key seen so far.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        best_key = '0;
        for (int i = 0; i < NUM; i++) begin
            if (req[i] && (!found || keys[i] < best_key)) begin
                found    = 1'b1;
                win_idx  = IDX_W'(i);
                best_key = keys[i];
            end
        end
    end
endmodule

// File: rtl/txarb_hold.sv
// Holds the chosen buffer for the duration of a frame.
// Captures the live winner on a start strobe while idle and a winner exists,
// and releases it on a done or abort pulse. Starts while active are ignored.
module txarb_hold #(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             done,
    input  logic             abort,
    input  logic             cand_valid,
    input  logic [IDX_W-1:0] cand_idx,
    output logic             active,
    output logic [IDX_W-1:0] held_idx
);
    // Frame ownership register: capture on start, release on done or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            held_idx <= '0;
        end else if (active) begin
            if (done || abort) active <= 1'b0;
        end else if (start && cand_valid) begin
            active   <= 1'b1;
            held_idx <= cand_idx;
        end
    end
endmodule

// File: rtl/txprio_arbiter.sv
// Top of the three-buffer transmit priority arbiter.
// Builds one key per buffer, selects the live minimum and latches it per frame.
// Assumes control strobes are single-cycle and synchronous to clk.
module txprio_arbiter
    import txarb_pkg::*;
#(
    parameter int ID_W   = 29,
    parameter int STD_W  = 11,
    parameter int PRIO_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rank_by_prio,
    input  logic [NUM_BUF-1:0]        tx_req,
    input  logic [NUM_BUF-1:0]        tx_ext,
    input  logic [NUM_BUF*ID_W-1:0]   tx_id,
    input  logic [NUM_BUF*PRIO_W-1:0] tx_prio,
    input  logic                      frame_start,
    input  logic                      frame_done,
    input  logic                      frame_abort,
    output logic                      next_valid,
    output logic [IDX_W-1:0]          next_idx,
    output logic                      frame_active,
    output logic [IDX_W-1:0]          frame_idx
);
    localparam int KEY_W = (ID_W > PRIO_W) ? ID_W : PRIO_W;

    logic [NUM_BUF-1:0][KEY_W-1:0] buf_key;

    // One key former per buffer.
    for (genvar b = 0; b < NUM_BUF; b++) begin : g_key
        txarb_keyform #(
            .ID_W  (ID_W),
            .STD_W (STD_W),
            .PRIO_W(PRIO_W),
            .KEY_W (KEY_W)
        ) u_key (
            .rank_by_prio(rank_by_prio),
            .is_ext      (tx_ext[b]),
            .id          (tx_id[b*ID_W +: ID_W]),
            .prio        (tx_prio[b*PRIO_W +: PRIO_W]),
            .key         (buf_key[b])
        );
    end

    txarb_minsel #(
        .NUM  (NUM_BUF),
        .KEY_W(KEY_W),
        .IDX_W(IDX_W)
    ) u_min (
        .req    (tx_req),
        .keys   (buf_key),
        .found  (next_valid),
        .win_idx(next_idx)
    );

    txarb_hold #(
        .IDX_W(IDX_W)
    ) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (frame_start),
        .done      (frame_done),
        .abort     (frame_abort),
        .cand_valid(next_valid),
        .cand_idx  (next_idx),
        .active    (frame_active),
        .held_idx  (frame_idx)
    );
endmodule

// File: rtl/txarb_checks.sv
// Property checker for txprio_arbiter, bound to every instance of it.
// Relates request inputs, the live choice and the held frame choice over time.
module txarb_checks
    import txarb_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_BUF-1:0] tx_req,
    input logic               frame_start,
    input logic               frame_done,
    input logic               frame_abort,
    input logic               next_valid,
    input logic [IDX_W-1:0]   next_idx,
    input logic               frame_active,
    input logic [IDX_W-1:0]   frame_idx
);
    assert_no_req_no_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req == '0) |-> !next_valid);

    assert_winner_requests_R5: assert property (@(posedge clk) disable iff (!rst_n)
        next_valid |-> (next_idx < IDX_W'(NUM_BUF) && tx_req[next_idx]));

    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active && frame_start && next_valid) |=>
            (frame_active && frame_idx == $past(next_idx)));

    assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && !frame_done && !frame_abort) |=>
            (frame_active && $stable(frame_idx)));

    assert_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && (frame_done || frame_abort)) |=> !frame_active);

    assert_empty_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_active && !next_valid) |=> !frame_active);
endmodule

bind txprio_arbiter txarb_checks u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_req      (tx_req),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .frame_abort (frame_abort),
    .next_valid  (next_valid),
    .next_idx    (next_idx),
    .frame_active(frame_active),
    .frame_idx   (frame_idx)
);

// File: tb/tb_txprio_arbiter.sv
module tb_txprio_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rank_by_prio = 1'b0;
    logic [2:0]  tx_req = '0;
    logic [2:0]  tx_ext = '0;
    logic [86:0] tx_id = '0;
    logic [23:0] tx_prio = '0;
    logic        frame_start = 1'b0;
    logic        frame_done = 1'b0;
    logic        frame_abort = 1'b0;
    logic        next_valid;
    logic [1:0]  next_idx;
    logic        frame_active;
    logic [1:0]  frame_idx;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    txprio_arbiter dut (
        .clk(clk), .rst_n(rst_n), .rank_by_prio(rank_by_prio),
        .tx_req(tx_req), .tx_ext(tx_ext), .tx_id(tx_id), .tx_prio(tx_prio),
        .frame_start(frame_start), .frame_done(frame_done), .frame_abort(frame_abort),
        .next_valid(next_valid), .next_idx(next_idx),
        .frame_active(frame_active), .frame_idx(frame_idx)
    );

    typedef struct packed {
        logic        mode;
        logic [2:0]  req;
        logic [2:0]  ext;
        logic [28:0] id0, id1, id2;
        logic [7:0]  p0, p1, p2;
        logic        ev;
        logic [1:0]  ei;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        // R1: nothing requested
        '{1'b0, 3'b000, 3'b111, 29'd1, 29'd2, 29'd3, 8'd1, 8'd2, 8'd3, 1'b0, 2'd0},
        // R2: smallest id in buffer 2
        '{1'b0, 3'b111, 3'b111, 29'd300, 29'd200, 29'd100, 8'd1, 8'd2, 8'd3, 1'b1, 2'd2},
        // R4: id tie between 0 and 1
        '{1'b0, 3'b111, 3'b111, 29'd5, 29'd5, 29'd9, 8'd9, 8'd1, 8'd1, 1'b1, 2'd0},
        // R5/R4: buffer 0 smallest but idle, tie 1 and 2
        '{1'b0, 3'b110, 3'b111, 29'd1, 29'd7, 29'd7, 8'd0, 8'd0, 8'd0, 1'b1, 2'd1},
        // R3: smallest prio in buffer 1, ids favour 0
        '{1'b1, 3'b111, 3'b111, 29'd1, 29'd2, 29'd3, 8'd40, 8'd10, 8'd20, 1'b1, 2'd1},
        // R4: all prio equal
        '{1'b1, 3'b111, 3'b111, 29'd9, 29'd8, 29'd7, 8'd9, 8'd9, 8'd9, 1'b1, 2'd0},
        // R5: only buffer 2 requests
        '{1'b1, 3'b100, 3'b111, 29'd1, 29'd1, 29'd1, 8'd0, 8'd0, 8'd200, 1'b1, 2'd2},
        // R6: standard id with upper junk masks to 5, beats extended 6
        '{1'b0, 3'b011, 3'b110, 29'h1FFF_F805, 29'd6, 29'd0, 8'd0, 8'd0, 8'd0, 1'b1, 2'd0},
        // R6: extended 2048 loses to standard 2047
        '{1'b0, 3'b011, 3'b101, 29'h800, 29'h1FFF_FFFF, 29'd0, 8'd0, 8'd0, 8'd0, 1'b1, 2'd1},
        // R3: prio 254 wins although id favours buffer 0
        '{1'b1, 3'b111, 3'b111, 29'd0, 29'd50, 29'd60, 8'd255, 8'd254, 8'd255, 1'b1, 2'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        rank_by_prio = v.mode;
        tx_req       = v.req;
        tx_ext       = v.ext;
        tx_id        = {v.id2, v.id1, v.id0};
        tx_prio      = {v.p2, v.p1, v.p0};
    endtask

    // Drives one strobe for a single cycle, returns at the following falling edge.
    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) frame_start = 1'b1;
        if (which == 1) frame_done  = 1'b1;
        if (which == 2) frame_abort = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        frame_done  = 1'b0;
        frame_abort = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 active after reset", int'(frame_active), 0);
        check("R11 idx after reset", int'(frame_idx), 0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            apply(VECS[k]);
            #2;
            check($sformatf("R1-R6 vec%0d valid", k), int'(next_valid), int'(VECS[k].ev));
            if (VECS[k].ev)
                check($sformatf("R2-R6 vec%0d idx", k), int'(next_idx), int'(VECS[k].ei));
        end

        // R10: start with nothing requested
        apply(VECS[0]);
        pulse(0);
        check("R10 start ignored with no request", int'(frame_active), 0);

        // R7: capture winner 2
        apply(VECS[1]);
        pulse(0);
        check("R7 active after start", int'(frame_active), 1);
        check("R7 captured idx", int'(frame_idx), 2);

        // R8: inputs change, live winner becomes 0, held stays 2
        apply(VECS[2]);
        @(negedge clk);
        check("R8 live winner moved", int'(next_idx), 0);
        check("R8 held idx stable", int'(frame_idx), 2);
        pulse(0);
        check("R8 restart ignored idx", int'(frame_idx), 2);
        check("R8 restart ignored active", int'(frame_active), 1);

        // R9: done releases, new start picks recomputed winner
        pulse(1);
        check("R9 done clears active", int'(frame_active), 0);
        apply(VECS[4]);
        pulse(0);
        check("R9 recomputed capture", int'(frame_idx), 1);
        pulse(2);
        check("R9 abort clears active", int'(frame_active), 0);
        check("R9 idx kept after abort", int'(frame_idx), 1);

        // R11: reset while active
        apply(VECS[6]);
        pulse(0);
        check("R7 capture buffer 2", int'(frame_idx), 2);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        check("R11 reset clears active", int'(frame_active), 0);
        check("R11 reset clears idx", int'(frame_idx), 0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule